// File: doc/BRIEF.md
# Per-core inter-processor interrupt register block

This block holds the interrupt state of one processor core inside a multi-core inter-processor interrupt unit. It keeps a pending status word, an enable word and a small mailbox of data words, and it drives one level-sensitive interrupt line toward the core. Software running on the core reaches the block through a simple 32-bit register port with an 8-bit byte offset. The unit's send logic sets pending bits through a separate internal port.

Pending bits cannot be written directly. Software sets them through a write-one-to-set register and removes them through a write-one-to-clear register. The interrupt line is stored state, and its raise and lower conditions are deliberately asymmetric. A set raises the line only when some pending bit is also enabled. A clear lowers it only when the status word becomes empty while the enable word is nonzero. In every other case the line keeps its value.

The mailbox is a window of word slots that both sides use to pass message payloads along with the interrupt.

Top module: `ipi_core_regs`

## Requirements
- R1: Registers are decoded per 32-bit word from the offset. Offset bits [1:0] select nothing, so every byte offset inside a word reaches that word (for example, offset 0x25 reaches mailbox word 1).
- R2: The status word is at word 0 (offsets 0x00–0x03) and is read-only. A write there changes neither the status word nor the interrupt line.
- R3: The enable word is at word 1 (offsets 0x04–0x07). A write replaces all of its bits, and a read returns the last value written.
- R4: A write to the set register (word 2, offsets 0x08–0x0B) ORs the data into the status word. In the following cycle the interrupt line is high if the new status ANDed with enable is nonzero; otherwise the line keeps its old value.
- R5: A write to the clear register (word 3, offsets 0x0C–0x0F) clears the status bits that are one in the data. The interrupt line goes low only if the resulting status is zero and the enable word is nonzero; otherwise it keeps its value, even when status becomes zero under a zero enable word.
- R6: The set and clear registers always read as zero.
- R7: The mailbox holds MBOX_WORDS words (8 by default) at offsets 0x20 to 0x20+4*MBOX_WORDS-1. The slot index is (offset − 0x20) >> 2, and each slot reads back the last value written to it.
- R8: Offsets outside the registers above read as zero and ignore writes. The cycle after any access to such an offset, acc_err is high for exactly that one cycle.
- R9: Reset clears status, enable, every mailbox word, the interrupt line, acc_rvalid and acc_err.
- R10: A pulse on int_set_valid acts exactly like a set-register write of int_set_bits. If it coincides with a bus write to the clear register, the clear is dropped and only the set takes effect.
- R11: A read returns its data on acc_rdata with acc_rvalid high in the cycle after the request, and acc_rvalid stays low after writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Register access request, one cycle per access |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_offset | input | 8 | Byte offset of the accessed register |
| acc_wdata | input | DATA_W | Write data |
| acc_rdata | output | DATA_W | Read data, valid with acc_rvalid |
| acc_rvalid | output | 1 | Read data valid, one cycle after a read |
| acc_err | output | 1 | One-cycle pulse after an access to an unmapped offset |
| int_set_valid | input | 1 | Internal set request from the send logic |
| int_set_bits | input | DATA_W | Bits to set in status on an internal request |
| irq_o | output | 1 | Level interrupt to the core |

## Verification
The hardest state to reach is the one the asymmetric rules leave behind: the interrupt line still high while the status word is empty. To get there, the stimulus raises the line with enable set, writes enable to zero, and clears every pending bit. It then checks that the line stays high and that only a later clear with a nonzero enable lowers it. A second hard case is an internal set and a bus clear landing in the same cycle. The bench drives both from one falling edge so that they meet at the same rising edge, then reads status back to confirm that the clear was dropped.

// File: rtl/ipi_core_pkg.sv
package ipi_core_pkg;

    // byte offset width of the register port
    localparam int OFS_W = 8;

    // byte offsets of the fixed registers
    localparam int OFS_STATUS = 'h00;
    localparam int OFS_ENABLE = 'h04;
    localparam int OFS_SET    = 'h08;
    localparam int OFS_CLEAR  = 'h0C;
    localparam int OFS_MBOX   = 'h20;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_STATUS,
        SEL_ENABLE,
        SEL_SET,
        SEL_CLEAR,
        SEL_MBOX
    } reg_sel_e;

endpackage

// File: rtl/ipi_reg_decode.sv
module ipi_reg_decode
    import ipi_core_pkg::*;
#(
    parameter int MBOX_WORDS = 8,
    localparam int IDX_W     = (MBOX_WORDS > 1) ? $clog2(MBOX_WORDS) : 1
) (
    input  logic [OFS_W-1:0] ofs,
    output reg_sel_e         sel,
    output logic [IDX_W-1:0] mbox_idx
);

    localparam int MBOX_END = OFS_MBOX + 4 * MBOX_WORDS;

    // full-offset range compares: bits [1:0] fall inside each word's range
    always_comb begin
        sel      = SEL_NONE;
        mbox_idx = IDX_W'((int'(ofs) - OFS_MBOX) >>> 2);
        if (int'(ofs) < OFS_STATUS + 4) begin
            sel = SEL_STATUS;
        end else if (int'(ofs) < OFS_ENABLE + 4) begin
            sel = SEL_ENABLE;
        end else if (int'(ofs) < OFS_SET + 4) begin
            sel = SEL_SET;
        end else if (int'(ofs) < OFS_CLEAR + 4) begin
            sel = SEL_CLEAR;
        end else if (int'(ofs) >= OFS_MBOX && int'(ofs) < MBOX_END) begin
            sel = SEL_MBOX;
        end
    end

endmodule

// File: rtl/ipi_status_unit.sv
module ipi_status_unit #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_enable,
    input  logic              wr_set,
    input  logic              wr_clear,
    input  logic [DATA_W-1:0] wdata,
    input  logic              int_set_valid,
    input  logic [DATA_W-1:0] int_set_bits,
    output logic [DATA_W-1:0] status_q,
    output logic [DATA_W-1:0] enable_q,
    output logic              irq_q
);

    typedef struct packed {
        logic [DATA_W-1:0] status;
        logic [DATA_W-1:0] enable;
        logic              irq;
    } st_t;

    st_t st_d, st_q;

    logic [DATA_W-1:0] set_mask_d;
    logic [DATA_W-1:0] clr_mask_d;
    logic              do_set_d;
    logic              do_clr_d;

    always_comb begin
        st_d       = st_q;
        do_set_d   = wr_set | int_set_valid;
        // the internal set wins over a coinciding bus clear
        do_clr_d   = wr_clear & ~int_set_valid;
        set_mask_d = (wr_set ? wdata : '0) | (int_set_valid ? int_set_bits : '0);
        clr_mask_d = do_clr_d ? wdata : '0;

        if (wr_enable) begin
            st_d.enable = wdata;
        end
        st_d.status = (st_q.status | set_mask_d) & ~clr_mask_d;

        if (do_set_d && ((st_d.status & st_d.enable) != '0)) begin
            st_d.irq = 1'b1;
        end else if (do_clr_d && (st_d.status == '0) && (st_d.enable != '0)) begin
            st_d.irq = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign status_q = st_q.status;
    assign enable_q = st_q.enable;
    assign irq_q    = st_q.irq;

endmodule

// File: rtl/ipi_mailbox.sv
module ipi_mailbox #(
    parameter int DATA_W     = 32,
    parameter int MBOX_WORDS = 8,
    localparam int IDX_W     = (MBOX_WORDS > 1) ? $clog2(MBOX_WORDS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] word_d [MBOX_WORDS];
    logic [DATA_W-1:0] word_q [MBOX_WORDS];

    for (genvar g = 0; g < MBOX_WORDS; g++) begin : g_slot
        always_comb begin
            word_d[g] = word_q[g];
            if (we && (int'(idx) == g)) begin
                word_d[g] = wdata;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                word_q[g] <= '0;
            end else begin
                word_q[g] <= word_d[g];
            end
        end
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < MBOX_WORDS; i++) begin
            if (int'(idx) == i) begin
                rdata = word_q[i];
            end
        end
    end

endmodule

// File: rtl/ipi_core_regs.sv
module ipi_core_regs
    import ipi_core_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int MBOX_WORDS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [7:0]        acc_offset,
    input  logic [DATA_W-1:0] acc_wdata,
    output logic [DATA_W-1:0] acc_rdata,
    output logic              acc_rvalid,
    output logic              acc_err,
    input  logic              int_set_valid,
    input  logic [DATA_W-1:0] int_set_bits,
    output logic              irq_o
);

    localparam int IDX_W = (MBOX_WORDS > 1) ? $clog2(MBOX_WORDS) : 1;

    typedef struct packed {
        logic [DATA_W-1:0] rdata;
        logic              rvalid;
        logic              err;
    } rd_t;

    reg_sel_e          sel;
    logic [IDX_W-1:0]  mbox_idx;
    logic [DATA_W-1:0] mbox_rdata;
    logic [DATA_W-1:0] status_q;
    logic [DATA_W-1:0] enable_q;
    logic              bus_wr;
    logic              bus_rd;
    rd_t               rd_d, rd_q;

    assign bus_wr = acc_valid & acc_write;
    assign bus_rd = acc_valid & ~acc_write;

    ipi_reg_decode #(.MBOX_WORDS(MBOX_WORDS)) u_decode (
        .ofs      (acc_offset),
        .sel      (sel),
        .mbox_idx (mbox_idx)
    );

    ipi_status_unit #(.DATA_W(DATA_W)) u_status (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_enable     (bus_wr && sel == SEL_ENABLE),
        .wr_set        (bus_wr && sel == SEL_SET),
        .wr_clear      (bus_wr && sel == SEL_CLEAR),
        .wdata         (acc_wdata),
        .int_set_valid (int_set_valid),
        .int_set_bits  (int_set_bits),
        .status_q      (status_q),
        .enable_q      (enable_q),
        .irq_q         (irq_o)
    );

    ipi_mailbox #(.DATA_W(DATA_W), .MBOX_WORDS(MBOX_WORDS)) u_mbox (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (bus_wr && sel == SEL_MBOX),
        .idx   (mbox_idx),
        .wdata (acc_wdata),
        .rdata (mbox_rdata)
    );

    always_comb begin
        rd_d        = '0;
        rd_d.err    = acc_valid && (sel == SEL_NONE);
        rd_d.rvalid = bus_rd;
        if (bus_rd) begin
            unique case (sel)
                SEL_STATUS: rd_d.rdata = status_q;
                SEL_ENABLE: rd_d.rdata = enable_q;
                SEL_MBOX:   rd_d.rdata = mbox_rdata;
                default:    rd_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else begin
            rd_q <= rd_d;
        end
    end

    assign acc_rdata  = rd_q.rdata;
    assign acc_rvalid = rd_q.rvalid;
    assign acc_err    = rd_q.err;

endmodule

// File: rtl/ipi_core_regs_chk.sv
module ipi_core_regs_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              acc_valid,
    input logic              acc_write,
    input logic [7:0]        acc_offset,
    input logic              acc_rvalid,
    input logic              acc_err,
    input logic              irq_o,
    input logic              int_set_valid,
    input logic [DATA_W-1:0] int_set_bits,
    input logic [DATA_W-1:0] status_q
);

    logic bus_set;
    logic bus_clr;

    assign bus_set = acc_valid && acc_write && acc_offset >= 8'h08 && acc_offset < 8'h0C;
    assign bus_clr = acc_valid && acc_write && acc_offset >= 8'h0C && acc_offset < 8'h10;

    // R4
    irq_rise_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> $past(bus_set || int_set_valid));

    // R5
    irq_fall_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_o) |-> ($past(bus_clr && !int_set_valid) && status_q == '0));

    // R2
    status_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_set && !bus_clr && !int_set_valid) |=> $stable(status_q));

    // R10
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int_set_valid |=> ((status_q & $past(int_set_bits)) == $past(int_set_bits)));

    // R11
    rvalid_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_rvalid |-> $past(acc_valid && !acc_write));

    // R8
    err_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_err |-> $past(acc_valid));

endmodule

bind ipi_core_regs ipi_core_regs_chk #(.DATA_W(DATA_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .acc_valid     (acc_valid),
    .acc_write     (acc_write),
    .acc_offset    (acc_offset),
    .acc_rvalid    (acc_rvalid),
    .acc_err       (acc_err),
    .irq_o         (irq_o),
    .int_set_valid (int_set_valid),
    .int_set_bits  (int_set_bits),
    .status_q      (status_q)
);

// File: tb/ipi_core_regs_bench.sv
`timescale 1ns/1ps
module ipi_core_regs_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0;
    logic        acc_write = 1'b0;
    logic [7:0]  acc_offset = '0;
    logic [31:0] acc_wdata = '0;
    logic [31:0] acc_rdata;
    logic        acc_rvalid;
    logic        acc_err;
    logic        int_set_valid = 1'b0;
    logic [31:0] int_set_bits = '0;
    logic        irq_o;

    int   n_chk = 0;
    int   n_err = 0;
    logic last_err;
    logic done = 1'b0;

    always #5 clk = ~clk;

    ipi_core_regs u_ipi_core_regs (
        .clk           (clk),
        .rst_n         (rst_n),
        .acc_valid     (acc_valid),
        .acc_write     (acc_write),
        .acc_offset    (acc_offset),
        .acc_wdata     (acc_wdata),
        .acc_rdata     (acc_rdata),
        .acc_rvalid    (acc_rvalid),
        .acc_err       (acc_err),
        .int_set_valid (int_set_valid),
        .int_set_bits  (int_set_bits),
        .irq_o         (irq_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] ofs, input logic [31:0] d);
        @(negedge clk);
        acc_valid = 1'b1; acc_write = 1'b1; acc_offset = ofs; acc_wdata = d;
        @(negedge clk);
        acc_valid = 1'b0; acc_write = 1'b0;
        last_err = acc_err;
        chk("R11 no rvalid on write", {31'd0, acc_rvalid}, 32'd0);
    endtask

    task automatic bus_read(input logic [7:0] ofs, output logic [31:0] d);
        @(negedge clk);
        acc_valid = 1'b1; acc_write = 1'b0; acc_offset = ofs;
        @(negedge clk);
        acc_valid = 1'b0;
        d = acc_rdata;
        last_err = acc_err;
        chk("R11 rvalid after read", {31'd0, acc_rvalid}, 32'd1);
    endtask

    task automatic int_set(input logic [31:0] bits);
        @(negedge clk);
        int_set_valid = 1'b1; int_set_bits = bits;
        @(negedge clk);
        int_set_valid = 1'b0; int_set_bits = '0;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        chk("R9 irq after reset", {31'd0, irq_o}, 32'd0);
        chk("R9 err after reset", {31'd0, acc_err}, 32'd0);
        bus_read(8'h00, d); chk("R9 status after reset", d, 32'd0);
        bus_read(8'h04, d); chk("R9 enable after reset", d, 32'd0);
        for (int i = 0; i < 8; i++) begin
            bus_read(8'(8'h20 + 4 * i), d); chk("R9 mailbox after reset", d, 32'd0);
        end
    endtask

    task automatic t_enable();
        logic [31:0] d;
        bus_write(8'h04, 32'hA5A5_0F0F);
        bus_read(8'h04, d); chk("R3 enable readback", d, 32'hA5A5_0F0F);
        bus_write(8'h06, 32'h0000_0100);
        bus_read(8'h04, d); chk("R3 enable replaced whole word", d, 32'h0000_0100);
        bus_write(8'h04, 32'h0);
    endtask

    task automatic t_status_ro();
        logic [31:0] d;
        bus_write(8'h04, 32'hFFFF_FFFF);
        bus_write(8'h00, 32'hFFFF_FFFF);
        chk("R2 irq after status write", {31'd0, irq_o}, 32'd0);
        bus_read(8'h00, d); chk("R2 status unchanged by write", d, 32'd0);
        bus_write(8'h04, 32'h0);
    endtask

    task automatic t_set();
        logic [31:0] d;
        bus_write(8'h04, 32'h0000_0001);
        bus_write(8'h08, 32'h0000_0002);
        chk("R4 masked set keeps irq low", {31'd0, irq_o}, 32'd0);
        bus_read(8'h00, d); chk("R4 status after set", d, 32'h2);
        bus_write(8'h08, 32'h0000_0001);
        chk("R4 enabled set raises irq", {31'd0, irq_o}, 32'd1);
        bus_read(8'h00, d); chk("R4 status ORed", d, 32'h3);
        bus_read(8'h08, d); chk("R6 set reads zero", d, 32'd0);
        bus_read(8'h0C, d); chk("R6 clear reads zero", d, 32'd0);
    endtask

    task automatic t_clear();
        logic [31:0] d;
        bus_write(8'h0C, 32'h0000_0001);
        chk("R5 irq held while status nonzero", {31'd0, irq_o}, 32'd1);
        bus_read(8'h00, d); chk("R5 status after partial clear", d, 32'h2);
        bus_write(8'h0C, 32'h0000_0002);
        chk("R5 irq lowered on empty status", {31'd0, irq_o}, 32'd0);
        bus_read(8'h00, d); chk("R5 status empty", d, 32'h0);
    endtask

    task automatic t_asym();
        logic [31:0] d;
        bus_write(8'h04, 32'h0000_0001);
        bus_write(8'h08, 32'h0000_0001);
        chk("R4 irq raised", {31'd0, irq_o}, 32'd1);
        bus_write(8'h04, 32'h0);
        chk("R3 enable write leaves irq", {31'd0, irq_o}, 32'd1);
        bus_write(8'h0C, 32'h0000_0001);
        chk("R5 irq kept with zero enable", {31'd0, irq_o}, 32'd1);
        bus_read(8'h00, d); chk("R5 status cleared", d, 32'h0);
        bus_write(8'h04, 32'h0000_0001);
        bus_write(8'h0C, 32'h0);
        chk("R5 irq lowered once enable nonzero", {31'd0, irq_o}, 32'd0);
        bus_write(8'h04, 32'h0);
    endtask

    task automatic t_mailbox();
        logic [31:0] d;
        for (int i = 0; i < 8; i++) begin
            bus_write(8'(8'h20 + 4 * i), 32'hC0DE_0000 + 32'(i * 17));
            chk("R8 no err on mailbox write", {31'd0, last_err}, 32'd0);
        end
        for (int i = 0; i < 8; i++) begin
            bus_read(8'(8'h20 + 4 * i), d);
            chk("R7 mailbox readback", d, 32'hC0DE_0000 + 32'(i * 17));
        end
        bus_write(8'h25, 32'h1234_5678);
        bus_read(8'h24, d); chk("R1 byte offset aliases word", d, 32'h1234_5678);
        bus_read(8'h3F, d); chk("R1 top byte of last slot", d, 32'hC0DE_0000 + 32'(7 * 17));
        bus_read(8'h28, d); chk("R7 neighbour slot untouched", d, 32'hC0DE_0000 + 32'(2 * 17));
    endtask

    task automatic t_unmapped();
        logic [31:0] d;
        bus_write(8'h40, 32'hFFFF_FFFF);
        chk("R8 err on unmapped write", {31'd0, last_err}, 32'd1);
        @(negedge clk);
        chk("R8 err single cycle", {31'd0, acc_err}, 32'd0);
        bus_read(8'h40, d); chk("R8 unmapped reads zero", d, 32'd0);
        chk("R8 err on unmapped read", {31'd0, last_err}, 32'd1);
        bus_write(8'h10, 32'hFFFF_FFFF);
        chk("R8 err at 0x10", {31'd0, last_err}, 32'd1);
        bus_read(8'h3C, d); chk("R8 mailbox unchanged", d, 32'hC0DE_0000 + 32'(7 * 17));
        chk("R8 no err on mapped read", {31'd0, last_err}, 32'd0);
        bus_read(8'h00, d); chk("R8 status unchanged", d, 32'd0);
        bus_read(8'h04, d); chk("R8 enable unchanged", d, 32'd0);
    endtask

    task automatic t_internal();
        logic [31:0] d;
        bus_write(8'h04, 32'h0000_0008);
        int_set(32'h0000_0008);
        chk("R10 internal set raises irq", {31'd0, irq_o}, 32'd1);
        // internal set and bus clear meet at one edge
        @(negedge clk);
        acc_valid = 1'b1; acc_write = 1'b1; acc_offset = 8'h0C; acc_wdata = 32'h0000_0008;
        int_set_valid = 1'b1; int_set_bits = 32'h0000_0010;
        @(negedge clk);
        acc_valid = 1'b0; acc_write = 1'b0; int_set_valid = 1'b0; int_set_bits = '0;
        bus_read(8'h00, d); chk("R10 clear dropped under set", d, 32'h0000_0018);
        chk("R10 irq stays high", {31'd0, irq_o}, 32'd1);
        bus_write(8'h0C, 32'h0000_0018);
        chk("R5 irq low after full clear", {31'd0, irq_o}, 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_enable();
        t_status_ro();
        t_set();
        t_clear();
        t_asym();
        t_mailbox();
        t_unmapped();
        t_internal();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        #2000000;
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_err++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

endmodule